// File: doc/BRIEF.md
# Hysteresis Sample Gate with Event Timestamps

This block sits on a single channel of 16-bit samples and passes on only the samples that fall inside periods of high activity. A sample's bit 0 carries the channel number and is ignored in the level test. The high state is set when a sample rises above an upper threshold and cleared only when one drops below a lower threshold, so noise near one level does not make the state chatter. Samples seen while the state is low are dropped.

Every word the block emits is tagged. Bit 0 is the channel, and bit 1 says whether the word is a timestamp (1) or a sample (0). When a high period starts, the first sample is marked and is followed at once by a timestamp. The timestamp is the per-channel count of accepted samples, cut into four 14-bit chunks and sent lowest chunk first. A 16-entry output FIFO absorbs bursts. While a timestamp is being sent, or while the FIFO has fewer than five free places, the sample input is held off, so no word is ever lost.

Top module: `hyst_gate_stamper`

## Requirements
- R1: A handshake on the config input loads both thresholds at once: the upper threshold from bits 31:16 and the lower threshold from bits 15:0. The config input is always ready. The new values apply to samples accepted after that clock edge.
- R2: The level test uses the sample with bit 0 forced to zero. Bit 0 affects only the channel field of the output words.
- R3: On each accepted sample, the high state becomes 1 if the masked sample is strictly above the upper threshold, becomes 0 if it is strictly below the lower threshold, and otherwise keeps its value.
- R4: An accepted sample whose updated high state is 1 is emitted as {sample[15:3], first, 1'b0, sample[0]}. The first bit is 1 only when the high state was 0 before this sample.
- R5: An accepted sample whose updated high state is 0 produces no output word.
- R6: Right after a sample with first=1, exactly four timestamp words {count[14*i +: 14], 1'b1, channel} follow, for i = 0, 1, 2, 3 in that order. No other word comes between them.
- R7: The count is a 56-bit number of accepted samples since reset, and the sample that starts the high period is included in it.
- R8: The input ready is 0 while timestamp words are still pending, or while the FIFO holds more than 11 words. Otherwise it is 1.
- R9: Output words leave in the order they were produced. Output valid is 1 exactly when the FIFO is non-empty and does not depend on output ready. A word that is presented stays stable until it is taken.
- R10: A synchronous active-high reset clears the thresholds, the high state, the count, any pending timestamp and the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_data | input | 16 | Sample; bit 0 is the channel number |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample taken on this edge if valid |
| cfg_data | input | 32 | {upper threshold, lower threshold} |
| cfg_valid | input | 1 | Config offered |
| cfg_ready | output | 1 | Always 1 |
| out_data | output | 16 | Tagged sample or timestamp word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |

## Verification
A wrong high state shows up within one accepted sample. Either a word appears that should have been dropped, or a first flag and its timestamp burst appear where none is due. A miscounted sample counter shows only in the next timestamp burst, so the checks need many high periods separated by low ones. A flaw in the ready rule or in the FIFO shows up as an overflowed, reordered or missing word, which the per-cycle comparison catches at the first affected output cycle. Random backpressure keeps the FIFO near its limit so that the five-place margin is exercised.

// File: rtl/hgs_pkg.sv
package hgs_pkg;
  localparam int SMP_W   = 16;
  localparam int CHUNK_W = SMP_W - 2;

  typedef logic [SMP_W-1:0] word_t;

  // sample with the channel bit forced to zero, used for the level test
  function automatic word_t clr_tag(word_t s);
    return s & ~word_t'(1);
  endfunction

  // tagged sample word: upper bits, first-of-period flag, kind=0, channel
  function automatic word_t fmt_sample(word_t s, logic first);
    return {s[SMP_W-1:3], first, 1'b0, s[0]};
  endfunction

  // timestamp word: one chunk of the count, kind=1, channel
  function automatic word_t fmt_stamp(logic [CHUNK_W-1:0] c, logic ch);
    return {c, 1'b1, ch};
  endfunction
endpackage

// File: rtl/hgs_hyst.sv
module hgs_hyst #(
  parameter int CNT_W = 56
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_load,
  input  logic [2*hgs_pkg::SMP_W-1:0] cfg_word,
  input  logic                      acc,
  input  hgs_pkg::word_t            smp,
  output logic                      high_q,
  output logic                      high_nx,
  output logic                      rise,
  output logic [CNT_W-1:0]          cnt_nx
);
  import hgs_pkg::*;

  word_t            thr_hi, thr_lo;
  word_t            masked;
  logic             above, below;
  logic [CNT_W-1:0] cnt_q;

  assign masked  = clr_tag(smp);
  assign above   = masked > thr_hi;
  assign below   = masked < thr_lo;
  assign high_nx = above ? 1'b1 : (below ? 1'b0 : high_q);
  assign rise    = acc && high_nx && !high_q;
  assign cnt_nx  = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_hi <= '0;
      thr_lo <= '0;
      high_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (cfg_load) begin
        thr_hi <= cfg_word[2*SMP_W-1:SMP_W];
        thr_lo <= cfg_word[SMP_W-1:0];
      end
      if (acc) begin
        high_q <= high_nx;
        cnt_q  <= cnt_nx;
      end
    end
  end

  p_set_above_r3: assert property (@(posedge clk) disable iff (rst)
    acc && above |=> high_q);
  p_clear_below_r3: assert property (@(posedge clk) disable iff (rst)
    acc && below && !above |=> !high_q);
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(high_q));
  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    acc |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/hgs_stamp.sv
module hgs_stamp #(
  parameter int CNT_W = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             ch_in,
  output logic             busy,
  output hgs_pkg::word_t   word
);
  import hgs_pkg::*;

  localparam int N_CHUNK = (CNT_W + CHUNK_W - 1) / CHUNK_W;
  localparam int SH_W    = N_CHUNK * CHUNK_W;
  localparam int LW      = $clog2(N_CHUNK + 1);

  logic [LW-1:0]   left;
  logic [SH_W-1:0] shreg;
  logic            ch_q;

  assign busy = left != '0;
  assign word = fmt_stamp(shreg[CHUNK_W-1:0], ch_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      shreg <= '0;
      ch_q  <= 1'b0;
    end else if (load) begin
      left  <= LW'(N_CHUNK);
      shreg <= SH_W'(cnt_in);
      ch_q  <= ch_in;
    end else if (busy) begin
      left  <= left - 1'b1;
      shreg <= shreg >> CHUNK_W;
    end
  end

  p_load_starts_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> busy && left == LW'(N_CHUNK));
  p_burst_ends_r6: assert property (@(posedge clk) disable iff (rst)
    busy && left == LW'(1) && !load |=> !busy);
  p_no_reload_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load);
endmodule

// File: rtl/hgs_fifo.sv
module hgs_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop_rdy,
  output logic                       dvalid,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  assign dvalid = count != '0;
  assign dout   = mem[rd_ptr];
  assign pop    = dvalid && pop_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    push && !pop |-> count < CW'(DEPTH));
  p_hold_word_r9: assert property (@(posedge clk) disable iff (rst)
    dvalid && !pop_rdy |=> dvalid && $stable(dout));
endmodule

// File: rtl/hyst_gate_stamper.sv
module hyst_gate_stamper #(
  parameter int CNT_W      = 56,
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] smp_data,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [31:0] cfg_data,
  input  logic        cfg_valid,
  output logic        cfg_ready,
  output logic [15:0] out_data,
  output logic        out_valid,
  input  logic        out_ready
);
  import hgs_pkg::*;

  localparam int N_CHUNK = (CNT_W + CHUNK_W - 1) / CHUNK_W;
  localparam int CW      = $clog2(FIFO_DEPTH + 1);
  localparam int MAX_FILL = FIFO_DEPTH - (N_CHUNK + 1);

  logic             acc, high_q, high_nx, rise, room, push_smp, push;
  logic [CNT_W-1:0] cnt_nx;
  logic             st_busy;
  word_t            st_word, fifo_din;
  logic [CW-1:0]    fill;

  assign cfg_ready = 1'b1;
  assign room      = fill <= CW'(MAX_FILL);
  assign smp_ready = !st_busy && room;
  assign acc       = smp_valid && smp_ready;
  assign push_smp  = acc && high_nx;
  assign push      = push_smp || st_busy;
  assign fifo_din  = st_busy ? st_word : fmt_sample(smp_data, rise);

  hgs_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk, .rst,
    .cfg_load (cfg_valid),
    .cfg_word (cfg_data),
    .acc,
    .smp      (smp_data),
    .high_q, .high_nx, .rise, .cnt_nx
  );

  hgs_stamp #(.CNT_W(CNT_W)) u_stamp (
    .clk, .rst,
    .load   (rise),
    .cnt_in (cnt_nx),
    .ch_in  (smp_data[0]),
    .busy   (st_busy),
    .word   (st_word)
  );

  hgs_fifo #(.DEPTH(FIFO_DEPTH), .W(SMP_W)) u_fifo (
    .clk, .rst,
    .push,
    .din     (fifo_din),
    .pop_rdy (out_ready),
    .dvalid  (out_valid),
    .dout    (out_data),
    .count   (fill)
  );

  p_rise_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    rise |=> st_busy && !smp_ready);
  p_drop_low_r5: assert property (@(posedge clk) disable iff (rst)
    acc && !high_nx |-> !push);
  p_cfg_open_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_ready);
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !st_busy);
endmodule

// File: tb/hyst_gate_stamper_bench.sv
`timescale 1ns/1ps
module hyst_gate_stamper_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] smp_data;
  logic        smp_valid;
  logic        smp_ready;
  logic [31:0] cfg_data;
  logic        cfg_valid;
  logic        cfg_ready;
  logic [15:0] out_data;
  logic        out_valid;
  logic        out_ready;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hyst_gate_stamper u_hyst_gate_stamper (
    .clk, .rst, .smp_data, .smp_valid, .smp_ready,
    .cfg_data, .cfg_valid, .cfg_ready,
    .out_data, .out_valid, .out_ready
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [15:0] q[$];
  bit          m_high;
  longint unsigned m_cnt, m_stamp;
  int          m_left;
  bit          m_ch;
  logic [15:0] m_hi, m_lo;

  function automatic bit model_ready();
    return (m_left == 0) && (q.size() <= DEPTH - 5);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_high = 0; m_cnt = 0; m_stamp = 0; m_left = 0; m_ch = 0;
      m_hi = '0; m_lo = '0;
    end else begin
      bit rdy;
      rdy = model_ready();
      if (q.size() != 0 && out_ready) void'(q.pop_front());
      if (m_left != 0) begin
        q.push_back({m_stamp[13:0], 1'b1, m_ch});
        m_stamp = m_stamp >> 14;
        m_left--;
      end else if (smp_valid && rdy) begin
        logic [15:0] mk;
        bit nh;
        mk = smp_data & 16'hFFFE;
        nh = (mk > m_hi) ? 1'b1 : ((mk < m_lo) ? 1'b0 : m_high);
        m_cnt = (m_cnt + 1) & 64'h00FF_FFFF_FFFF_FFFF;
        if (nh) q.push_back({smp_data[15:3], nh && !m_high, 1'b0, smp_data[0]});
        if (nh && !m_high) begin
          m_left = 4; m_stamp = m_cnt; m_ch = smp_data[0];
        end
        m_high = nh;
      end
      if (cfg_valid) begin
        m_hi = cfg_data[31:16];
        m_lo = cfg_data[15:0];
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(smp_ready === model_ready(), "R8 input ready", 64'(smp_ready), 64'(model_ready()));
      check(out_valid === (q.size() != 0), "R9 output valid", 64'(out_valid), 64'(q.size() != 0));
      if (out_valid && q.size() != 0)
        check(out_data === q[0], "R2 R3 R4 R5 R6 R7 output word", 64'(out_data), 64'(q[0]));
    end
  end

  task automatic send(input logic [15:0] d);
    smp_data  = d;
    smp_valid = 1'b1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [15:0] hi, input logic [15:0] lo);
    cfg_data  = {hi, lo};
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] exp_w [6];
    bit rdy_seen;
    rst = 1'b1; smp_data = '0; smp_valid = 1'b0;
    cfg_data = '0; cfg_valid = 1'b0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R10 valid in reset", 64'(out_valid), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    check(smp_ready === 1'b1, "R10 ready after reset", 64'(smp_ready), 64'(1));
    check(cfg_ready === 1'b1, "R1 config always ready", 64'(cfg_ready), 64'(1));

    // directed: upper 0x0100, lower 0x0080
    set_cfg(16'h0100, 16'h0080);
    send(16'h0101);   // masked equals upper: stays low (R2, R3)
    send(16'h0103);   // rises, channel 1, count 2
    send(16'h0090);   // between: holds high
    send(16'h007E);   // below lower: dropped
    exp_w = '{16'h0105, 16'h000B, 16'h0003, 16'h0003, 16'h0003, 16'h0090};
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(out_valid === 1'b1, "R9 directed valid", 64'(out_valid), 64'(1));
      check(out_data === exp_w[i], "R4 R6 R7 directed word", 64'(out_data), 64'(exp_w[i]));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    check(out_valid === 1'b0, "R5 dropped sample absent", 64'(out_valid), 64'(0));

    // random stimulus with gaps, backpressure and config changes
    set_cfg(16'h0800, 16'h0400);
    rdy_seen = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (smp_valid && rdy_seen) smp_valid = 1'b0;
      cfg_valid = 1'b0;
      if (!smp_valid && ($urandom_range(0, 3) != 0)) begin
        smp_data  = 16'($urandom_range(0, 16'h0FFF));
        smp_valid = 1'b1;
      end
      if ($urandom_range(0, 499) == 0) begin
        logic [15:0] lo;
        lo = 16'($urandom_range(16'h0200, 16'h0700));
        cfg_data  = {lo + 16'($urandom_range(0, 16'h0600)), lo};
        cfg_valid = 1'b1;
      end
      out_ready = ($urandom_range(0, 9) < 7);
      rdy_seen  = smp_ready;
    end
    @(negedge clk);
    smp_valid = 1'b0; cfg_valid = 1'b0; out_ready = 1'b1;
    repeat (40) @(negedge clk);
    check(out_valid === 1'b0, "R9 drained", 64'(out_valid), 64'(0));
    finish_run();
  end
endmodule